// File: doc/BRIEF.md
# Cascadable Master Interrupt Prioritizer

This block gathers sixteen interrupt request lines and drives the single interrupt line of a processor. Each request is latched into a pending bit. A mask register can hold a pending line back. Among the pending, unmasked lines, the one with the lowest index wins. The output interrupt is raised when the winner outranks every line now in service. A line of equal or lower rank than the one in service is held back until that service finishes.

The processor reads two bytes over the life of an interrupt. The first comes on an acknowledge read strobe. The same byte comes again on an end-of-interrupt read strobe. For an ordinary line the byte is a positive vector: a programmable 7-bit base plus the line number. A line that software has marked as fed by a subordinate controller returns its line number minus sixteen instead. That value is negative and has bit 7 set, so the processor knows to forward the read to that subordinate. An acknowledge moves the winning line from pending to in service. An end-of-interrupt retires the highest-priority in-service line, and the remaining requests then compete again. A small write port loads the mask, the cascade marks, the vector base and a default vector.

Top module: `irq_master_prio`

## Requirements
- R1: After reset, all pending and in-service bits are clear and no line is masked or cascaded. The base and default vector are 0, `intOut` is 0 and `rdByte` is 0.
- R2: A one-cycle pulse on `reqIn[i]` sets the pending bit of line i at that clock edge. If the line is eligible, `intOut` is high after that edge, and it stays high until the line is acknowledged or masked.
- R3: Priority is fixed, and line 0 is the highest. With several lines eligible, an acknowledge serves the lowest index.
- R4: For a line whose cascade bit is 0, the acknowledge byte is `{1'b0, (base + line) mod 128}`. Bit 7 is therefore 0.
- R5: For a line whose cascade bit is 1, the acknowledge byte is `line - 16` in 8-bit two's complement, which is `8'hF0 | line`.
- R6: A line whose mask bit is 1 never raises or holds `intOut` and is never served by an acknowledge. Its pending bit is kept, so clearing the mask makes it eligible again.
- R7: A served acknowledge clears the line's pending bit and sets its in-service bit. `rdByte` holds the byte from the edge of the strobe cycle onward.
- R8: While line k is in service, `intOut` is raised only by an eligible line with an index below k.
- R9: An end-of-interrupt read returns the byte of the lowest-index in-service line and clears that line's in-service bit. Pending lines then compete again.
- R10: An acknowledge with no line able to raise `intOut` returns `{1'b0, default}` and changes no state. So does an end-of-interrupt with nothing in service.
- R11: A write with `wrEn` high loads one register chosen by `wrAddr`: 0 loads the mask (bit i is line i, 1 masks it), 1 loads the cascade bits, 2 loads the base from `wrData[6:0]`, and 3 loads the default vector from `wrData[6:0]`.
- R12: If `ackRd` and `eoiRd` are high in the same cycle, only the acknowledge is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 16 | Request lines, latched into pending while high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select for writes |
| wrData | input | 16 | Write data |
| ackRd | input | 1 | Acknowledge read strobe, one cycle |
| eoiRd | input | 1 | End-of-interrupt read strobe, one cycle |
| intOut | output | 1 | Interrupt request to the processor |
| rdByte | output | 8 | Byte returned by the last acknowledge or end-of-interrupt read |

## Verification
`intOut` is formed from registered state without any further stage. It therefore reflects a request pulse, a mask write, an acknowledge or an end-of-interrupt one clock edge after the stimulus. `rdByte` is registered at the edge that samples the read strobe, so it also holds its new value one edge later. The bench drives every input 1 ns after a rising edge and samples all outputs 1 ns after the following edge. Each expected byte is worked out from the line number, the base and the cascade pattern that the bench last wrote.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int VEC_W       = 7;   // width of a positive vector
  localparam int CASC_OFFSET = 16;  // subtracted from a cascaded line number
  localparam int LINE_FIELD_W = 8;

  typedef struct packed {
    logic                    ackGrant;
    logic                    eoiGrant;
    logic                    idleRead;
    logic [LINE_FIELD_W-1:0] ackLine;
    logic [LINE_FIELD_W-1:0] eoiLine;
  } irqmStrobes_t;
endpackage

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
  import irqm_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pending,
  input  logic [NUM_LINES-1:0] inService,
  input  logic [NUM_LINES-1:0] mask,
  input  logic                 ackRd,
  input  logic                 eoiRd,
  output irqmStrobes_t         str,
  output logic                 intOut
);
  localparam int LINE_W = $clog2(NUM_LINES);

  function automatic logic [LINE_W:0] lowestSet(input logic [NUM_LINES-1:0] v);
    logic [LINE_W:0] r;
    r = '0;
    for (int k = NUM_LINES - 1; k >= 0; k--) begin
      if (v[k]) r = {1'b1, LINE_W'(k)};
    end
    return r;
  endfunction

  logic [NUM_LINES-1:0] eligible;
  logic [LINE_W:0]      elSel;
  logic [LINE_W:0]      isSel;
  logic                 elFound;
  logic                 isFound;
  logic [LINE_W-1:0]    elIdx;
  logic [LINE_W-1:0]    isIdx;

  always_comb begin
    eligible = pending & ~mask;
    elSel    = lowestSet(eligible);
    isSel    = lowestSet(inService);
    elFound  = elSel[LINE_W];
    elIdx    = elSel[LINE_W-1:0];
    isFound  = isSel[LINE_W];
    isIdx    = isSel[LINE_W-1:0];
    intOut   = elFound && (!isFound || (elIdx < isIdx));
  end

  always_comb begin
    str.ackGrant = ackRd && intOut;
    str.eoiGrant = eoiRd && !ackRd && isFound;
    str.idleRead = (ackRd && !intOut) || (eoiRd && !ackRd && !isFound);
    str.ackLine  = LINE_FIELD_W'(elIdx);
    str.eoiLine  = LINE_FIELD_W'(isIdx);
  end

  AST_GRANTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({str.ackGrant, str.eoiGrant, str.idleRead}) <= 1); // R12
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && eoiRd) |-> !str.eoiGrant); // R12
endmodule

// File: rtl/irqm_datapath.sv
module irqm_datapath
  import irqm_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [NUM_LINES-1:0] wrData,
  input  irqmStrobes_t         str,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] inService,
  output logic [NUM_LINES-1:0] mask,
  output logic [7:0]           rdByte
);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] cascEn;
  logic [VEC_W-1:0]     vecBase;
  logic [VEC_W-1:0]     defVec;
  logic [NUM_LINES-1:0] ackHot;
  logic [NUM_LINES-1:0] eoiHot;
  logic [7:0]           ackByte;
  logic [7:0]           eoiByte;

  function automatic logic [7:0] byteFor(input logic [LINE_FIELD_W-1:0] ln,
                                         input logic isCasc,
                                         input logic [VEC_W-1:0] base);
    if (isCasc) return ln - 8'(CASC_OFFSET);
    return {1'b0, VEC_W'(base + ln[VEC_W-1:0])};
  endfunction

  always_comb begin
    ackHot  = '0;
    eoiHot  = '0;
    if (str.ackGrant) ackHot[str.ackLine[LINE_W-1:0]] = 1'b1;
    if (str.eoiGrant) eoiHot[str.eoiLine[LINE_W-1:0]] = 1'b1;
    ackByte = byteFor(str.ackLine, cascEn[str.ackLine[LINE_W-1:0]], vecBase);
    eoiByte = byteFor(str.eoiLine, cascEn[str.eoiLine[LINE_W-1:0]], vecBase);
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask    <= '0;
      cascEn  <= '0;
      vecBase <= '0;
      defVec  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        2'd0:    mask    <= wrData;
        2'd1:    cascEn  <= wrData;
        2'd2:    vecBase <= wrData[VEC_W-1:0];
        default: defVec  <= wrData[VEC_W-1:0];
      endcase
    end
  end

  // request and service state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      inService <= '0;
    end else begin
      pending   <= (pending | reqIn) & ~ackHot;
      inService <= (inService | ackHot) & ~eoiHot;
    end
  end

  // read byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdByte <= '0;
    end else if (str.ackGrant) begin
      rdByte <= ackByte;
    end else if (str.eoiGrant) begin
      rdByte <= eoiByte;
    end else if (str.idleRead) begin
      rdByte <= {1'b0, defVec};
    end
  end

  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    str.ackGrant |-> (!mask[str.ackLine[LINE_W-1:0]] && pending[str.ackLine[LINE_W-1:0]])); // R6
  AST_GRANT_ABOVE_ISR: assert property (@(posedge clk) disable iff (!rstN)
    str.ackGrant |-> ((inService & ((NUM_LINES'(2) << str.ackLine[LINE_W-1:0]) - NUM_LINES'(1))) == '0)); // R8
  AST_ACK_MOVES_LINE: assert property (@(posedge clk) disable iff (!rstN)
    str.ackGrant |=> (inService[$past(str.ackLine[LINE_W-1:0])] && !pending[$past(str.ackLine[LINE_W-1:0])])); // R7
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    str.eoiGrant |=> !inService[$past(str.eoiLine[LINE_W-1:0])]); // R9
  AST_CASC_NEGATIVE: assert property (@(posedge clk) disable iff (!rstN)
    (str.ackGrant && cascEn[str.ackLine[LINE_W-1:0]]) |=> rdByte[7]); // R5
  AST_NORMAL_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    (str.ackGrant && !cascEn[str.ackLine[LINE_W-1:0]]) |=> !rdByte[7]); // R4
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (str.idleRead && !wrEn) |=> ($stable(inService) && !rdByte[7])); // R10
endmodule

// File: rtl/irq_master_prio.sv
module irq_master_prio
  import irqm_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic                 ackRd,
  input  logic                 eoiRd,
  output logic                 intOut,
  output logic [7:0]           rdByte
);
  irqmStrobes_t         str;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] inService;
  logic [NUM_LINES-1:0] mask;

  irqm_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pending   (pending),
    .inService (inService),
    .mask      (mask),
    .ackRd     (ackRd),
    .eoiRd     (eoiRd),
    .str       (str),
    .intOut    (intOut)
  );

  irqm_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .str       (str),
    .pending   (pending),
    .inService (inService),
    .mask      (mask),
    .rdByte    (rdByte)
  );
endmodule

// File: tb/tb_irq_master_prio.sv
module tb_irq_master_prio;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqIn = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        ackRd = 1'b0;
  logic        eoiRd = 1'b0;
  logic        intOut;
  logic [7:0]  rdByte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_master_prio dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ackRd(ackRd), .eoiRd(eoiRd), .intOut(intOut), .rdByte(rdByte)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic pulse(logic [15:0] m);
    reqIn = m;
    tick();
    reqIn = '0;
  endtask

  task automatic ack();
    ackRd = 1'b1;
    tick();
    ackRd = 1'b0;
  endtask

  task automatic eoi();
    eoiRd = 1'b1;
    tick();
    eoiRd = 1'b0;
  endtask

  function automatic int expByte(int ln, int base, logic [15:0] casc);
    if (casc[ln]) return (ln - 16) & 8'hFF;
    return (base + ln) & 7'h7F;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bases[3] = '{0, 9, 121};
    logic [15:0] cpats[2] = '{16'h0000, 16'hA5C3};
    #1;
    repeat (3) tick();
    chk("R1 intOut", int'(intOut), 0);
    chk("R1 rdByte", int'(rdByte), 0);
    rstN = 1'b1;
    tick();
    pulse(16'h0001);
    ack();
    chk("R1 base and cascade zero", int'(rdByte), 0);
    eoi();

    // R4 R5 R11 sweep over base, cascade pattern and line
    foreach (bases[b]) begin
      wr(2'd2, 16'(bases[b]));
      foreach (cpats[c]) begin
        wr(2'd1, cpats[c]);
        for (int i = 0; i < 16; i++) begin
          pulse(16'(1) << i);
          chk("R2 intOut after request", int'(intOut), 1);
          ack();
          chk(cpats[c][i] ? "R5 cascade byte" : "R4 vector byte",
              int'(rdByte), expByte(i, bases[b], cpats[c]));
          chk("R7 intOut after ack", int'(intOut), 0);
          eoi();
          chk("R9 eoi repeats byte", int'(rdByte), expByte(i, bases[b], cpats[c]));
          chk("R9 intOut after eoi", int'(intOut), 0);
        end
      end
    end
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);

    // R3 all pairs of lines
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        pulse((16'(1) << i) | (16'(1) << j));
        ack();
        chk("R3 higher priority first", int'(rdByte), i);
        chk("R8 lower line held", int'(intOut), 0);
        eoi();
        chk("R9 eoi byte", int'(rdByte), i);
        chk("R9 rearbitrate", int'(intOut), 1);
        ack();
        chk("R3 second line", int'(rdByte), j);
        eoi();
      end
    end

    // R6 R10 mask and default vector
    wr(2'd3, 16'h0055);
    wr(2'd0, 16'h0008);
    pulse(16'h0008);
    chk("R6 masked no int", int'(intOut), 0);
    ack();
    chk("R10 default on idle ack", int'(rdByte), 8'h55);
    chk("R10 state unchanged", int'(intOut), 0);
    wr(2'd0, 16'h0000);
    chk("R6 unmask raises int", int'(intOut), 1);
    ack();
    chk("R6 served after unmask", int'(rdByte), 3);
    wr(2'd0, 16'h0002);
    pulse(16'h0002);
    chk("R6 masked under service", int'(intOut), 0);
    eoi();
    chk("R9 eoi line 3", int'(rdByte), 3);
    chk("R6 masked after eoi", int'(intOut), 0);
    wr(2'd0, 16'h0000);
    ack();
    chk("R6 line 1 after unmask", int'(rdByte), 1);
    eoi();
    eoi();
    chk("R10 default on idle eoi", int'(rdByte), 8'h55);

    // R8 nesting
    pulse(16'h0020);
    ack();
    chk("R8 first line 5", int'(rdByte), 5);
    pulse(16'h0200);
    chk("R8 line 9 held", int'(intOut), 0);
    pulse(16'h0004);
    chk("R8 line 2 preempts", int'(intOut), 1);
    ack();
    chk("R8 nested byte", int'(rdByte), 2);
    eoi();
    chk("R9 retires line 2", int'(rdByte), 2);
    chk("R8 line 9 still held", int'(intOut), 0);
    eoi();
    chk("R9 retires line 5", int'(rdByte), 5);
    chk("R9 line 9 rises", int'(intOut), 1);
    ack();
    chk("R3 line 9 served", int'(rdByte), 9);
    eoi();

    // R12 simultaneous strobes
    pulse(16'h0010);
    ackRd = 1'b1; eoiRd = 1'b1;
    tick();
    ackRd = 1'b0; eoiRd = 1'b0;
    chk("R12 ack performed", int'(rdByte), 4);
    eoi();
    chk("R12 eoi was ignored", int'(rdByte), 4);
    eoi();
    chk("R12 nothing left", int'(rdByte), 8'h55);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule